// File: doc/BRIEF.md
# Cascadable Dual Interval Timer

This block holds two down-counting interval timers, A and B, each with a reload latch, a control register and a counter that is twice the host byte width. A timer runs while its start bit is set and moves one step for each count event from its selected source. When it passes zero it reloads from its latch and raises a one-cycle underflow pulse for the interrupt unit. It can run continuously or stop itself after one period. Timer B can count clock-enable ticks, external count pulses or timer A underflows, so the two can be chained into one long timer.

Each timer can drive a port pin, either as a pulse for each underflow or as a level that toggles on each underflow. A serial-shift step counter is tied to timer A. A write to the serial data register arms it, and it reports completion after sixteen timer A underflows. The host reaches everything through a byte-wide write port and a separate combinational read port.

Top module: `cascade_timer_pair`

## Requirements
- R1: After reset both control registers read 0x04, both counters read 0xFFFF, the latches hold 0xFFFF, and the underflow, serial-done and pin-enable outputs are low.
- R2: A started timer decrements once per count event. An event at count 0 reloads the latch instead, and the timer's underflow output (irq_a/irq_b) is high for the one cycle after that edge. A latch value L therefore gives a period of L+1 events.
- R3: Control bit 3 set selects one-shot mode. An underflow in this mode clears start bit 0 and the counter keeps the reloaded value. With bit 3 clear the timer keeps running.
- R4: Writing a latch low byte (address 0 for A, 2 for B) changes only the latch. Writing a latch high byte (address 1 or 3) also loads the counter if the timer is stopped. In one-shot mode it loads the counter and sets the start bit. A running continuous timer keeps its count.
- R5: Writing a control register (address 4 for A, 5 for B) with bit 4 set copies the latch into the counter. Bit 4 always reads back 0, and so does bit 7.
- R6: Timer A counts clock-enable ticks (tick high in a cycle) when control A bit 5 is 0. When bit 5 is 1 it counts cycles with cnt_in high.
- R7: Timer B control bits 6:5 select its source: 00 ticks, 01 cnt_in cycles, 10 timer A underflows, 11 timer A underflows in cycles with cnt_in high. In the two chained modes timer B holds while timer A is stopped.
- R8: Control bit 1 enables the timer's pin output. With bit 2 = 1 the pin is a level that goes high when the timer starts and inverts on each underflow. With bit 2 = 0 the pin carries the one-cycle underflow pulse.
- R9: A write to address 6 while timer A runs continuously with control A bit 6 set arms a step counter of 16. Each timer A underflow decrements it, and ser_done is high for one cycle after the underflow that takes it to 0.
- R10: Reads have no side effects. Address 0/1 returns the low/high byte of counter A, 2/3 those of counter B, 4/5 control A/B, 6 the serial data byte, and 7 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Clock-enable count event |
| cnt_in | input | 1 | External count input, counted per cycle high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | BYTE_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | BYTE_W | Combinational read data |
| irq_a | output | 1 | Timer A underflow pulse |
| irq_b | output | 1 | Timer B underflow pulse |
| ser_done | output | 1 | Serial step counter finished pulse |
| pin_a | output | 1 | Timer A port pin level |
| pin_a_en | output | 1 | Timer A port pin enable |
| pin_b | output | 1 | Timer B port pin level |
| pin_b_en | output | 1 | Timer B port pin enable |

## Verification
The bench builds the block with its defaults: BYTE_W = 8 gives 16-bit counters and SER_BITS = 8 gives a serial count of sixteen. Small latch values, including 0 and 1, make underflows, multi-period wraps and a full serial count happen within tens of ticks. A latch above 255 exercises the high byte. Chained timer B is tested with timer A running, stopped and gated by cnt_in, so the same few underflows exercise every source mode.

// File: rtl/ctp_pkg.sv
package ctp_pkg;
  localparam int CTRL_W = 7;

  localparam int BIT_RUN     = 0;
  localparam int BIT_PIN_EN  = 1;
  localparam int BIT_TOGGLE  = 2;
  localparam int BIT_ONESHOT = 3;
  localparam int BIT_FORCE   = 4;
  localparam int BIT_SRC_LO  = 5;
  localparam int BIT_SRC_HI  = 6;

  localparam logic [CTRL_W-1:0] CTRL_RESET = 7'h04;

  typedef enum logic [2:0] {
    RA_A_LO  = 3'd0,
    RA_A_HI  = 3'd1,
    RA_B_LO  = 3'd2,
    RA_B_HI  = 3'd3,
    RA_CTL_A = 3'd4,
    RA_CTL_B = 3'd5,
    RA_SER   = 3'd6,
    RA_NONE  = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    BSRC_TICK    = 2'b00,
    BSRC_PIN     = 2'b01,
    BSRC_CHAIN   = 2'b10,
    BSRC_CHAIN_G = 2'b11
  } b_src_e;
endpackage

// File: rtl/ctp_timer_core.sv
module ctp_timer_core
  import ctp_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  src_evt,
  input  logic                  wr_lo,
  input  logic                  wr_hi,
  input  logic                  wr_ctl,
  input  logic [BYTE_W-1:0]     wdata,
  output logic [CTRL_W-1:0]     ctl_q,
  output logic [2*BYTE_W-1:0]   cnt_q,
  output logic [2*BYTE_W-1:0]   latch_q,
  output logic                  uf_evt,
  output logic                  uf_pulse,
  output logic                  pin_level
);
  localparam int CNT_W = 2 * BYTE_W;

  logic                count_evt;
  logic [CTRL_W-1:0]   ctl_d;
  logic [CNT_W-1:0]    cnt_d;
  logic [CNT_W-1:0]    latch_d;
  logic                tog_q;
  logic                tog_d;
  logic                start_rise;

  // one counting step: hold, decrement, or reload at zero
  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] cur,
                                                  input logic [CNT_W-1:0] rel,
                                                  input logic             evt);
    if (!evt) return cur;
    if (cur == '0) return rel;
    return cur - 1'b1;
  endfunction

  assign count_evt = src_evt && ctl_q[BIT_RUN];
  assign uf_evt    = count_evt && (cnt_q == '0);

  // counting first, host write applied on top of it
  always_comb begin
    ctl_d   = ctl_q;
    latch_d = latch_q;
    cnt_d   = step_count(cnt_q, latch_q, count_evt);
    if (uf_evt && ctl_q[BIT_ONESHOT]) ctl_d[BIT_RUN] = 1'b0;
    if (wr_lo) latch_d[BYTE_W-1:0] = wdata;
    if (wr_hi) begin
      latch_d[CNT_W-1:BYTE_W] = wdata;
      if (!ctl_d[BIT_RUN] || ctl_d[BIT_ONESHOT]) cnt_d = latch_d;
      if (ctl_d[BIT_ONESHOT]) ctl_d[BIT_RUN] = 1'b1;
    end
    if (wr_ctl) begin
      ctl_d            = wdata[CTRL_W-1:0];
      ctl_d[BIT_FORCE] = 1'b0;
      if (wdata[BIT_FORCE]) cnt_d = latch_q;
    end
  end

  assign start_rise = !ctl_q[BIT_RUN] && ctl_d[BIT_RUN];

  always_comb begin
    tog_d = tog_q;
    if (start_rise)  tog_d = 1'b1;
    else if (uf_evt) tog_d = ~tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= CTRL_RESET;
      cnt_q    <= '1;
      latch_q  <= '1;
      tog_q    <= 1'b0;
      uf_pulse <= 1'b0;
    end else begin
      ctl_q    <= ctl_d;
      cnt_q    <= cnt_d;
      latch_q  <= latch_d;
      tog_q    <= tog_d;
      uf_pulse <= uf_evt;
    end
  end

  assign pin_level = ctl_q[BIT_TOGGLE] ? tog_q : uf_pulse;
endmodule

// File: rtl/ctp_ser_counter.sv
module ctp_ser_counter #(
  parameter int SER_BITS = 8,
  parameter int REM_W    = $clog2(2 * SER_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_wr,
  input  logic             ser_mode,
  input  logic             a_running,
  input  logic             a_oneshot,
  input  logic             a_uf,
  output logic [REM_W-1:0] remain_q,
  output logic             done_pulse
);
  localparam logic [REM_W-1:0] FULL = REM_W'(2 * SER_BITS);

  logic [REM_W-1:0] after_step;
  logic             step;
  logic [REM_W-1:0] remain_d;

  assign step       = a_uf && ser_mode && !a_oneshot && (remain_q != '0);
  assign after_step = step ? remain_q - 1'b1 : remain_q;

  always_comb begin
    remain_d = after_step;
    if (arm_wr) begin
      if (!ser_mode) remain_d = '0;
      else if (a_running && after_step == '0) remain_d = FULL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q   <= '0;
      done_pulse <= 1'b0;
    end else begin
      remain_q   <= remain_d;
      done_pulse <= step && (after_step == '0);
    end
  end
endmodule

// File: rtl/ctp_reg_decode.sv
module ctp_reg_decode
  import ctp_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                wr_en,
  input  logic [2:0]          wr_addr,
  input  logic [2:0]          rd_addr,
  input  logic [2*BYTE_W-1:0] cnt_a,
  input  logic [2*BYTE_W-1:0] cnt_b,
  input  logic [CTRL_W-1:0]   ctl_a,
  input  logic [CTRL_W-1:0]   ctl_b,
  input  logic [BYTE_W-1:0]   ser_data,
  output logic [1:0]          wr_lo,
  output logic [1:0]          wr_hi,
  output logic [1:0]          wr_ctl,
  output logic                wr_ser,
  output logic [BYTE_W-1:0]   rd_data
);
  assign wr_lo[0]  = wr_en && (wr_addr == RA_A_LO);
  assign wr_hi[0]  = wr_en && (wr_addr == RA_A_HI);
  assign wr_lo[1]  = wr_en && (wr_addr == RA_B_LO);
  assign wr_hi[1]  = wr_en && (wr_addr == RA_B_HI);
  assign wr_ctl[0] = wr_en && (wr_addr == RA_CTL_A);
  assign wr_ctl[1] = wr_en && (wr_addr == RA_CTL_B);
  assign wr_ser    = wr_en && (wr_addr == RA_SER);

  function automatic logic [BYTE_W-1:0] pick(input logic [2:0] a);
    case (a)
      RA_A_LO:  return cnt_a[BYTE_W-1:0];
      RA_A_HI:  return cnt_a[2*BYTE_W-1:BYTE_W];
      RA_B_LO:  return cnt_b[BYTE_W-1:0];
      RA_B_HI:  return cnt_b[2*BYTE_W-1:BYTE_W];
      RA_CTL_A: return BYTE_W'(ctl_a);
      RA_CTL_B: return BYTE_W'(ctl_b);
      RA_SER:   return ser_data;
      default:  return '0;
    endcase
  endfunction

  assign rd_data = pick(rd_addr);
endmodule

// File: rtl/cascade_timer_pair.sv
module cascade_timer_pair
  import ctp_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int SER_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cnt_in,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              irq_a,
  output logic              irq_b,
  output logic              ser_done,
  output logic              pin_a,
  output logic              pin_a_en,
  output logic              pin_b,
  output logic              pin_b_en
);
  localparam int NUM_TMR   = 2;
  localparam int CNT_W     = 2 * BYTE_W;
  localparam int SER_REM_W = $clog2(2 * SER_BITS + 1);

  logic [CTRL_W-1:0] ctl_v   [NUM_TMR];
  logic [CNT_W-1:0]  cnt_v   [NUM_TMR];
  logic [CNT_W-1:0]  latch_v [NUM_TMR];
  logic [NUM_TMR-1:0] src_evt, uf_v, ufp_v, pin_v;
  logic [NUM_TMR-1:0] wr_lo, wr_hi, wr_ctl;
  logic               wr_ser;
  logic [BYTE_W-1:0]  ser_data_q;
  logic [SER_REM_W-1:0] ser_remain;
  logic               b_chain_evt;

  ctp_reg_decode #(.BYTE_W(BYTE_W)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .cnt_a(cnt_v[0]), .cnt_b(cnt_v[1]), .ctl_a(ctl_v[0]), .ctl_b(ctl_v[1]),
    .ser_data(ser_data_q),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_ctl(wr_ctl), .wr_ser(wr_ser),
    .rd_data(rd_data)
  );

  // timer A source: ticks or external count cycles
  assign src_evt[0] = ctl_v[0][BIT_SRC_LO] ? cnt_in : tick;

  // timer B source: four-way selection, two of them chained to A
  assign b_chain_evt = uf_v[0];
  always_comb begin
    case (b_src_e'(ctl_v[1][BIT_SRC_HI:BIT_SRC_LO]))
      BSRC_TICK:    src_evt[1] = tick;
      BSRC_PIN:     src_evt[1] = cnt_in;
      BSRC_CHAIN:   src_evt[1] = b_chain_evt;
      BSRC_CHAIN_G: src_evt[1] = b_chain_evt && cnt_in;
      default:      src_evt[1] = 1'b0;
    endcase
  end

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    ctp_timer_core #(.BYTE_W(BYTE_W)) u_core (
      .clk(clk), .rst_n(rst_n), .src_evt(src_evt[t]),
      .wr_lo(wr_lo[t]), .wr_hi(wr_hi[t]), .wr_ctl(wr_ctl[t]), .wdata(wr_data),
      .ctl_q(ctl_v[t]), .cnt_q(cnt_v[t]), .latch_q(latch_v[t]),
      .uf_evt(uf_v[t]), .uf_pulse(ufp_v[t]), .pin_level(pin_v[t])
    );
  end

  ctp_ser_counter #(.SER_BITS(SER_BITS), .REM_W(SER_REM_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .arm_wr(wr_ser),
    .ser_mode(ctl_v[0][BIT_SRC_HI]), .a_running(ctl_v[0][BIT_RUN]),
    .a_oneshot(ctl_v[0][BIT_ONESHOT]), .a_uf(uf_v[0]),
    .remain_q(ser_remain), .done_pulse(ser_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ser_data_q <= '0;
    else if (wr_ser) ser_data_q <= wr_data;
  end

  assign irq_a    = ufp_v[0];
  assign irq_b    = ufp_v[1];
  assign pin_a_en = ctl_v[0][BIT_PIN_EN];
  assign pin_b_en = ctl_v[1][BIT_PIN_EN];
  assign pin_a    = pin_a_en && pin_v[0];
  assign pin_b    = pin_b_en && pin_v[1];
endmodule

// File: rtl/ctp_checker.sv
module ctp_checker
  import ctp_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int REM_W  = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [2:0]          wr_addr,
  input logic                uf_a,
  input logic                uf_b,
  input logic [CTRL_W-1:0]   ctl_a,
  input logic [CTRL_W-1:0]   ctl_b,
  input logic [2*BYTE_W-1:0] cnt_a,
  input logic [2*BYTE_W-1:0] cnt_b,
  input logic [2*BYTE_W-1:0] latch_a,
  input logic [2*BYTE_W-1:0] latch_b,
  input logic                irq_a,
  input logic                ser_done,
  input logic [REM_W-1:0]    ser_remain
);
  logic a_touch, b_touch;
  assign a_touch = wr_en && (wr_addr == RA_A_HI || wr_addr == RA_CTL_A);
  assign b_touch = wr_en && (wr_addr == RA_B_HI || wr_addr == RA_CTL_B);

  assert_reload_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    uf_a && !a_touch |=> cnt_a == $past(latch_a));

  assert_reload_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
    uf_b && !b_touch |=> cnt_b == $past(latch_b));

  assert_irq_after_uf_R2: assert property (@(posedge clk) disable iff (!rst_n)
    uf_a |=> irq_a);

  assert_oneshot_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    uf_a && ctl_a[BIT_ONESHOT] && !a_touch |=> !ctl_a[BIT_RUN]);

  assert_lo_write_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == RA_A_LO && !ctl_a[BIT_RUN] |=> $stable(cnt_a));

  assert_chain_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_b[BIT_RUN] && ctl_b[BIT_SRC_HI] && !ctl_a[BIT_RUN] && !b_touch |=> $stable(cnt_b));

  assert_ser_done_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ser_done |-> $past(ser_remain) == 1);
endmodule

bind cascade_timer_pair ctp_checker #(.BYTE_W(BYTE_W), .REM_W(SER_REM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .uf_a(uf_v[0]), .uf_b(uf_v[1]), .ctl_a(ctl_v[0]), .ctl_b(ctl_v[1]),
  .cnt_a(cnt_v[0]), .cnt_b(cnt_v[1]), .latch_a(latch_v[0]), .latch_b(latch_v[1]),
  .irq_a(irq_a), .ser_done(ser_done), .ser_remain(ser_remain)
);

// File: tb/cascade_timer_pair_tb.sv
module cascade_timer_pair_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       cnt_in = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [2:0] rd_addr = 3'd0;
  logic [7:0] rd_data;
  logic irq_a, irq_b, ser_done, pin_a, pin_a_en, pin_b, pin_b_en;

  int n_checks = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  cascade_timer_pair dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_in(cnt_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_a(irq_a), .irq_b(irq_b), .ser_done(ser_done),
    .pin_a(pin_a), .pin_a_en(pin_a_en), .pin_b(pin_b), .pin_b_en(pin_b_en)
  );

  // latch value and event count per vector (continuous timer A)
  localparam int NV = 7;
  localparam int VL [NV] = '{5, 5, 5, 0, 300, 1, 16'h1234};
  localparam int VK [NV] = '{3, 6, 14, 4, 10, 7, 20};

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  task automatic rd16(input logic [2:0] lo_a, output int v);
    int lo, hi;
    rd(lo_a, lo);
    rd(lo_a + 3'd1, hi);
    v = (hi << 8) | lo;
  endtask

  task automatic run(input int n, output int irqs);
    irqs = 0;
    tick = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq_a) irqs++;
    end
    tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog R1 act=timeout exp=finish");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    int v, v2, irqs, hits, at;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd4, v); check("R1 ctrl A", v, 8'h04);
    rd(3'd5, v); check("R1 ctrl B", v, 8'h04);
    rd16(3'd0, v); check("R1 count A", v, 16'hFFFF);
    rd16(3'd2, v); check("R1 count B", v, 16'hFFFF);
    check("R1 irq/ser/pin en", {irq_a, irq_b, ser_done, pin_a_en, pin_b_en}, 0);
    wr(3'd4, 8'h10); wr(3'd4, 8'h00);
    rd16(3'd0, v); check("R1 latch A after force", v, 16'hFFFF);

    // R2 vector table, continuous timer A
    for (int i = 0; i < NV; i++) begin
      wr(3'd4, 8'h00);
      wr(3'd0, 8'(VL[i] & 8'hFF));
      wr(3'd1, 8'(VL[i] >> 8));
      wr(3'd4, 8'h01);
      run(VK[i], irqs);
      wr(3'd4, 8'h00);
      rd16(3'd0, v);
      check("R2 vector count", v, VL[i] - (VK[i] % (VL[i] + 1)));
      check("R2 vector underflows", irqs, VK[i] / (VL[i] + 1));
    end

    // R3 / R4 one-shot: high write loads and starts
    wr(3'd4, 8'h08);
    wr(3'd0, 8'h03);
    wr(3'd1, 8'h00);
    rd(3'd4, v); check("R4 one-shot hi write starts", v, 8'h09);
    rd16(3'd0, v); check("R4 one-shot hi write loads", v, 3);
    run(4, irqs);
    check("R3 one-shot one underflow", irqs, 1);
    rd(3'd4, v); check("R3 one-shot start cleared", v, 8'h08);
    run(3, irqs);
    rd16(3'd0, v); check("R3 one-shot stays reloaded", v, 3);

    // R4 low byte only latch, stopped high write loads
    wr(3'd4, 8'h00);
    wr(3'd0, 8'h10);
    rd16(3'd0, v); check("R4 low write keeps count", v, 3);
    wr(3'd1, 8'h01);
    rd16(3'd0, v); check("R4 stopped hi write loads", v, 16'h0110);
    wr(3'd4, 8'h01);
    wr(3'd1, 8'h02);
    rd16(3'd0, v); check("R4 running hi write keeps count", v, 16'h0110);

    // R5 force load
    wr(3'd4, 8'h11);
    rd16(3'd0, v); check("R5 force load copies latch", v, 16'h0210);
    rd(3'd4, v); check("R5 strobe reads 0", v, 8'h01);
    wr(3'd4, 8'h00);

    // R6 external count source for A
    wr(3'd4, 8'h21);
    run(3, irqs);
    rd16(3'd0, v); check("R6 ticks ignored in ext mode", v, 16'h0210);
    cnt_in = 1'b1;
    repeat (3) @(negedge clk);
    cnt_in = 1'b0;
    rd16(3'd0, v); check("R6 cnt_in cycles counted", v, 16'h020D);
    wr(3'd4, 8'h00);

    // R7 chained timer B
    wr(3'd0, 8'h01); wr(3'd1, 8'h00);
    wr(3'd2, 8'h0A); wr(3'd3, 8'h00);
    wr(3'd5, 8'h41);
    wr(3'd4, 8'h01);
    run(6, irqs);
    rd16(3'd2, v); check("R7 chain counts A underflows", v, 7);
    wr(3'd4, 8'h00);
    run(5, irqs);
    rd16(3'd2, v); check("R7 chain holds with A stopped", v, 7);
    wr(3'd5, 8'h61);
    wr(3'd4, 8'h01);
    run(4, irqs);
    rd16(3'd2, v); check("R7 gated chain cnt_in low", v, 7);
    cnt_in = 1'b1;
    run(4, irqs);
    cnt_in = 1'b0;
    rd16(3'd2, v); check("R7 gated chain cnt_in high", v, 5);
    wr(3'd5, 8'h01);
    run(3, irqs);
    rd16(3'd2, v); check("R7 tick source", v, 2);
    wr(3'd4, 8'h00); wr(3'd5, 8'h00);

    // R8 pin outputs
    wr(3'd0, 8'h02); wr(3'd1, 8'h00);
    check("R8 pin disabled", {pin_a_en, pin_a}, 0);
    wr(3'd4, 8'h07);
    check("R8 toggle high at start", {pin_a_en, pin_a}, 3);
    run(3, irqs);
    check("R8 toggle inverts on underflow", pin_a, 0);
    run(3, irqs);
    check("R8 toggle inverts again", pin_a, 1);
    wr(3'd4, 8'h03);
    hits = 0; at = 0;
    tick = 1'b1;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (pin_a) begin hits++; if (at == 0) at = i; end
    end
    tick = 1'b0;
    check("R8 pulse mode count", hits, 2);
    check("R8 pulse mode timing", at, 3);
    wr(3'd4, 8'h00);

    // R9 serial step counter
    wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    wr(3'd4, 8'h41);
    wr(3'd6, 8'hA5);
    hits = 0; at = 0;
    tick = 1'b1;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      if (ser_done) begin hits++; if (at == 0) at = i; end
    end
    tick = 1'b0;
    check("R9 serial done once", hits, 1);
    check("R9 serial done after 16 underflows", at, 16);
    wr(3'd4, 8'h00);

    // R10 read map and non-destructive reads
    rd(3'd6, v); check("R10 serial data readback", v, 8'hA5);
    rd16(3'd0, v); rd16(3'd0, v2);
    check("R10 repeated read equal", v2, v);
    rd(3'd7, v); check("R10 unused address", v, 0);

    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule